// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Cache

This block caches virtual-to-physical page translations for 4 KB pages. A requester presents a 32-bit virtual address with an access kind (read, write or execute) and a privilege flag, and in the same cycle gets back hit or miss, a 28-bit physical address and a protection-fault flag. The lookup is combinational over registered state. On a miss, the requester walks the page tables itself and installs the result through the fill port. The cache never produces a translation it was not given.

Storage is 64 entries, organised as 32 sets of 2 ways. The set is chosen by virtual address bits 16..12, and the upper 15 bits are kept as the tag. Each entry holds a 16-bit physical page number, four permission bits (read, write, execute, user-accessible) and a dirty bit. Each set keeps a single recency bit. When a fill displaces a live entry, the displaced page number and its dirty state are reported for one cycle, so that the page-table entry can be marked modified. A flush input invalidates everything when the address space changes.

Top module: `xlat_cache`

## Requirements
- R1: A lookup hits when set `lk_vaddr_i[16:12]` holds a valid entry whose tag equals `lk_vaddr_i[31:17]`. The physical address is then `{ppn, lk_vaddr_i[11:0]}`. A different tag, or the same tag in another set, misses.
- R2: On a miss, `lk_hit_o`, `lk_fault_o` and `lk_paddr_o` are all 0. After reset every entry is invalid.
- R3: The access code is 00 read, 01 write, 10 execute. Code 11 is reserved and always faults on a hit. A hit whose access bit is clear gives `lk_hit_o`=1, `lk_fault_o`=1 and `lk_paddr_o`=0.
- R4: A hit with `lk_user_i`=1 on an entry whose user bit is 0 faults. Kernel accesses ignore the user bit.
- R5: A non-faulting write hit sets the entry's dirty bit. A faulting access changes neither the dirty bit nor the set's recency.
- R6: A fill uses way 0 if it is invalid, then way 1 if it is invalid, and otherwise the least recently used way. A non-faulting hit or a fill makes its way the most recently used.
- R7: In the cycle after a fill displaces a valid entry, `evict_valid_o` is 1 for one cycle. `evict_vpn_o` then holds that entry's {tag, set} and `evict_dirty_o` its dirty bit. Otherwise `evict_valid_o` is 0.
- R8: A fill whose page number is already present overwrites that same way, clears its dirty bit and produces no eviction notice. The other way of the set is left untouched.
- R9: `flush_i` invalidates every entry at the next edge. A fill in the same cycle is dropped and no eviction notice is produced.
- R10: When a fill and a lookup target the same set in the same cycle, the lookup reports a miss and changes nothing. Lookups to other sets are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_acc_i | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| lk_user_i | input | 1 | 1 for a user-mode access |
| lk_hit_o | output | 1 | Translation found |
| lk_paddr_o | output | 28 | Physical address, 0 unless a permitted hit |
| lk_fault_o | output | 1 | Hit whose permissions deny the access |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number being installed |
| fill_ppn_i | input | 16 | Physical page number being installed |
| fill_rd_i | input | 1 | Read allowed |
| fill_wr_i | input | 1 | Write allowed |
| fill_ex_i | input | 1 | Execute allowed |
| fill_usr_i | input | 1 | User mode allowed |
| flush_i | input | 1 | Invalidate all entries |
| evict_valid_o | output | 1 | A valid entry was displaced at the previous edge |
| evict_vpn_o | output | 20 | Displaced virtual page number |
| evict_dirty_o | output | 1 | Displaced entry had been written |

## Verification
The bench builds the block with its default parameters: 32-bit virtual addresses, 28-bit physical addresses, 4 KB pages and 32 sets. Because of this, pages that differ only in tag bits 31..17 collide in one set. Three or four fills to the same set therefore drive the invalid-way choice, the recency-based victim choice and both clean and dirty eviction notices. Same-set and different-set pairs of fill and lookup expose the fill-priority rule. Refills and faulting writes are observed only through later hits and eviction notices.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef struct packed {
    logic usr;
    logic ex;
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  perm_t      perm_i,
  input  logic [1:0] acc_i,
  input  logic       user_i,
  output logic       deny_o
);
  logic kind_deny;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_RD:  kind_deny = !perm_i.rd;
      ACC_WR:  kind_deny = !perm_i.wr;
      ACC_EX:  kind_deny = !perm_i.ex;
      default: kind_deny = 1'b1;
    endcase
  end

  assign deny_o = kind_deny | (user_i & !perm_i.usr);
endmodule

// File: rtl/xlat_way_bank.sv
module xlat_way_bank
  import xlat_pkg::*;
#(
  parameter  int SETS  = 32,
  parameter  int TAG_W = 15,
  parameter  int PPN_W = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  // lookup side
  input  logic [SET_W-1:0] a_set_i,
  output logic             a_vld_o,
  output logic [TAG_W-1:0] a_tag_o,
  output logic [PPN_W-1:0] a_ppn_o,
  output perm_t            a_perm_o,
  input  logic             dset_en_i,
  // fill side
  input  logic [SET_W-1:0] b_set_i,
  output logic             b_vld_o,
  output logic [TAG_W-1:0] b_tag_o,
  output logic             b_dirty_o,
  input  logic             wr_en_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  perm_t            wr_perm_i
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q   [SETS];
  logic [PPN_W-1:0] ppn_q   [SETS];
  perm_t            perm_q  [SETS];
  logic             dirty_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vld_q <= '0;
    else if (flush_i)   vld_q <= '0;
    else if (wr_en_i)   vld_q[b_set_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[b_set_i]   <= wr_tag_i;
      ppn_q[b_set_i]   <= wr_ppn_i;
      perm_q[b_set_i]  <= wr_perm_i;
      dirty_q[b_set_i] <= 1'b0;
    end
    if (dset_en_i) dirty_q[a_set_i] <= 1'b1;
  end

  assign a_vld_o   = vld_q[a_set_i];
  assign a_tag_o   = tag_q[a_set_i];
  assign a_ppn_o   = ppn_q[a_set_i];
  assign a_perm_o  = perm_q[a_set_i];
  assign b_vld_o   = vld_q[b_set_i];
  assign b_tag_o   = tag_q[b_set_i];
  assign b_dirty_o = dirty_q[b_set_i];
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter  int SETS  = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             use_en_i,
  input  logic [SET_W-1:0] use_set_i,
  input  logic             use_way_i,
  input  logic             fill_en_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [1:0]       fill_vld_i,
  input  logic [1:0]       fill_hit_i,
  output logic             victim_o
);
  logic [SETS-1:0] lru_q;  // index of least recently used way

  always_comb begin
    if (|fill_hit_i)        victim_o = fill_hit_i[1];
    else if (!fill_vld_i[0]) victim_o = 1'b0;
    else if (!fill_vld_i[1]) victim_o = 1'b1;
    else                     victim_o = lru_q[fill_set_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else begin
      for (int s = 0; s < SETS; s++) begin
        if (fill_en_i && fill_set_i == SET_W'(s))     lru_q[s] <= ~victim_o;
        else if (use_en_i && use_set_i == SET_W'(s)) lru_q[s] <= ~use_way_i;
      end
    end
  end

  assert_lru_after_use_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_en_i && !(fill_en_i && fill_set_i == use_set_i))
      |=> lru_q[$past(use_set_i)] != $past(use_way_i));

  assert_lru_after_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> lru_q[$past(fill_set_i)] != $past(victim_o));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter  int VA_W   = 32,
  parameter  int PA_W   = 28,
  parameter  int PAGE_W = 12,
  parameter  int SETS   = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int TAG_W  = VPN_W - SET_W,
  localparam int PPN_W  = PA_W - PAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic [1:0]       lk_acc_i,
  input  logic             lk_user_i,
  output logic             lk_hit_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  output logic             lk_fault_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             fill_ex_i,
  input  logic             fill_usr_i,
  input  logic             flush_i,
  output logic             evict_valid_o,
  output logic [VPN_W-1:0] evict_vpn_o,
  output logic             evict_dirty_o
);
  localparam int WAYS = 2;

  logic [SET_W-1:0] lk_set, f_set;
  logic [TAG_W-1:0] lk_tag, f_tag;
  assign lk_set = lk_vaddr_i[PAGE_W +: SET_W];
  assign lk_tag = lk_vaddr_i[VA_W-1 -: TAG_W];
  assign f_set  = fill_vpn_i[SET_W-1:0];
  assign f_tag  = fill_vpn_i[VPN_W-1 -: TAG_W];

  logic             fill_go, clash, victim, ok, deny, sel;
  logic [WAYS-1:0]  a_vld, a_match, b_vld, b_match, b_dirty, hit_way;
  logic [TAG_W-1:0] a_tag [WAYS];
  logic [TAG_W-1:0] b_tag [WAYS];
  logic [PPN_W-1:0] a_ppn [WAYS];
  perm_t            a_perm [WAYS];
  perm_t            f_perm;

  assign fill_go = fill_valid_i & !flush_i;
  assign clash   = fill_valid_i && (f_set == lk_set);  // fill wins the set
  assign f_perm  = '{usr: fill_usr_i, ex: fill_ex_i, wr: fill_wr_i, rd: fill_rd_i};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    xlat_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .a_set_i   (lk_set),
      .a_vld_o   (a_vld[w]),
      .a_tag_o   (a_tag[w]),
      .a_ppn_o   (a_ppn[w]),
      .a_perm_o  (a_perm[w]),
      .dset_en_i (ok && hit_way[w] && lk_acc_i == ACC_WR),
      .b_set_i   (f_set),
      .b_vld_o   (b_vld[w]),
      .b_tag_o   (b_tag[w]),
      .b_dirty_o (b_dirty[w]),
      .wr_en_i   (fill_go && victim == w[0]),
      .wr_tag_i  (f_tag),
      .wr_ppn_i  (fill_ppn_i),
      .wr_perm_i (f_perm)
    );
    assign a_match[w] = a_vld[w] && a_tag[w] == lk_tag;
    assign b_match[w] = b_vld[w] && b_tag[w] == f_tag;
    assign hit_way[w] = a_match[w] && lk_valid_i && !clash;
  end

  assign sel      = hit_way[1];
  assign lk_hit_o = |hit_way;

  xlat_perm u_perm (
    .perm_i (a_perm[sel]),
    .acc_i  (lk_acc_i),
    .user_i (lk_user_i),
    .deny_o (deny)
  );

  assign lk_fault_o = lk_hit_o & deny;
  assign ok         = lk_hit_o & !deny;
  assign lk_paddr_o = ok ? {a_ppn[sel], lk_vaddr_i[PAGE_W-1:0]} : '0;

  xlat_lru #(.SETS(SETS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .use_en_i   (ok),
    .use_set_i  (lk_set),
    .use_way_i  (sel),
    .fill_en_i  (fill_go),
    .fill_set_i (f_set),
    .fill_vld_i (b_vld),
    .fill_hit_i (b_match),
    .victim_o   (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evict_valid_o <= 1'b0;
      evict_vpn_o   <= '0;
      evict_dirty_o <= 1'b0;
    end else begin
      evict_valid_o <= fill_go && !(|b_match) && b_vld[victim];
      evict_vpn_o   <= {b_tag[victim], f_set};
      evict_dirty_o <= b_dirty[victim];
    end
  end

  assert_single_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(a_match) <= 1);

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);

  assert_evict_follows_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> $past(fill_go));
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int CLK_P = 10;
  localparam int Q     = CLK_P / 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_vaddr_i = '0;
  logic [1:0]  lk_acc_i = '0;
  logic        lk_user_i = 1'b0;
  logic        lk_hit_o, lk_fault_o;
  logic [27:0] lk_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [15:0] fill_ppn_i = '0;
  logic        fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_ex_i = 1'b0, fill_usr_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        evict_valid_o, evict_dirty_o;
  logic [19:0] evict_vpn_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_acc_i(lk_acc_i),
    .lk_user_i(lk_user_i), .lk_hit_o(lk_hit_o), .lk_paddr_o(lk_paddr_o),
    .lk_fault_o(lk_fault_o), .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i),
    .fill_ppn_i(fill_ppn_i), .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i),
    .fill_ex_i(fill_ex_i), .fill_usr_i(fill_usr_i), .flush_i(flush_i),
    .evict_valid_o(evict_valid_o), .evict_vpn_o(evict_vpn_o), .evict_dirty_o(evict_dirty_o)
  );

  function automatic logic [31:0] va(input int tag, input int set, input int off);
    return {tag[14:0], set[4:0], off[11:0]};
  endfunction

  function automatic logic [19:0] vpn(input int tag, input int set);
    return {tag[14:0], set[4:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Starts and ends on a falling edge; samples before the rising edge.
  task automatic probe(input logic [31:0] a, input logic [1:0] acc, input logic usr,
                       input string req, input logic eh, input logic ef,
                       input logic [27:0] ep);
    lk_valid_i = 1'b1; lk_vaddr_i = a; lk_acc_i = acc; lk_user_i = usr;
    #Q;
    chk({req, " hit"}, 32'(lk_hit_o), 32'(eh));
    chk({req, " fault"}, 32'(lk_fault_o), 32'(ef));
    chk({req, " paddr"}, 32'(lk_paddr_o), 32'(ep));
    @(negedge clk);
    lk_valid_i = 1'b0;
  endtask

  task automatic drive_fill(input logic [19:0] v, input logic [15:0] p, input logic [3:0] urwx);
    fill_valid_i = 1'b1; fill_vpn_i = v; fill_ppn_i = p;
    {fill_usr_i, fill_rd_i, fill_wr_i, fill_ex_i} = urwx;
  endtask

  task automatic fill(input logic [19:0] v, input logic [15:0] p, input logic [3:0] urwx,
                      input string req, input logic ev, input logic [19:0] evpn,
                      input logic ed);
    drive_fill(v, p, urwx);
    @(negedge clk);
    fill_valid_i = 1'b0;
    #Q;
    chk({req, " evict_valid"}, 32'(evict_valid_o), 32'(ev));
    if (ev) begin
      chk({req, " evict_vpn"}, 32'(evict_vpn_o), 32'(evpn));
      chk({req, " evict_dirty"}, 32'(evict_dirty_o), 32'(ed));
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    probe(va(1, 3, 0), 2'b00, 1'b0, "R2 reset miss", 1'b0, 1'b0, '0);
    chk("R7 no evict after reset", 32'(evict_valid_o), 32'd0);
  endtask

  task automatic t_basic;
    fill(vpn(1, 3), 16'h1234, 4'b1111, "R7 fill empty", 1'b0, '0, 1'b0);
    probe(va(1, 3, 12'habc), 2'b00, 1'b1, "R1 hit", 1'b1, 1'b0, {16'h1234, 12'habc});
    probe(va(2, 3, 12'habc), 2'b00, 1'b0, "R2 tag miss", 1'b0, 1'b0, '0);
    probe(va(1, 4, 12'h001), 2'b00, 1'b0, "R1 other set miss", 1'b0, 1'b0, '0);
  endtask

  task automatic t_perm;
    fill(vpn(5, 6), 16'h0042, 4'b0100, "R3 fill ro", 1'b0, '0, 1'b0);
    probe(va(5, 6, 12'h010), 2'b00, 1'b0, "R3 read ok", 1'b1, 1'b0, {16'h0042, 12'h010});
    probe(va(5, 6, 12'h010), 2'b01, 1'b0, "R3 write denied", 1'b1, 1'b1, '0);
    probe(va(5, 6, 12'h010), 2'b10, 1'b0, "R3 exec denied", 1'b1, 1'b1, '0);
    probe(va(5, 6, 12'h010), 2'b00, 1'b1, "R4 user on kernel page", 1'b1, 1'b1, '0);
    probe(va(1, 3, 12'h020), 2'b11, 1'b0, "R3 reserved code", 1'b1, 1'b1, '0);
    probe(va(1, 3, 12'h020), 2'b10, 1'b1, "R4 user on user page", 1'b1, 1'b0, {16'h1234, 12'h020});
  endtask

  task automatic t_replace;
    fill(vpn(10, 5), 16'h0a0a, 4'b1111, "R6 fill way0", 1'b0, '0, 1'b0);
    fill(vpn(11, 5), 16'h0b0b, 4'b1111, "R6 fill way1", 1'b0, '0, 1'b0);
    probe(va(10, 5, 0), 2'b01, 1'b0, "R5 write hit", 1'b1, 1'b0, {16'h0a0a, 12'h000});
    fill(vpn(12, 5), 16'h0c0c, 4'b1111, "R6 R7 clean victim", 1'b1, vpn(11, 5), 1'b0);
    probe(va(11, 5, 0), 2'b00, 1'b0, "R6 victim gone", 1'b0, 1'b0, '0);
    probe(va(10, 5, 4), 2'b00, 1'b0, "R6 survivor", 1'b1, 1'b0, {16'h0a0a, 12'h004});
    probe(va(12, 5, 8), 2'b01, 1'b0, "R5 write new", 1'b1, 1'b0, {16'h0c0c, 12'h008});
    probe(va(10, 5, 0), 2'b00, 1'b0, "R6 touch", 1'b1, 1'b0, {16'h0a0a, 12'h000});
    fill(vpn(13, 5), 16'h0d0d, 4'b1111, "R5 R7 dirty victim", 1'b1, vpn(12, 5), 1'b1);
  endtask

  task automatic t_refill;
    fill(vpn(10, 5), 16'h0777, 4'b1111, "R8 refill no notice", 1'b0, '0, 1'b0);
    probe(va(10, 5, 1), 2'b00, 1'b0, "R8 new ppn", 1'b1, 1'b0, {16'h0777, 12'h001});
    probe(va(13, 5, 2), 2'b00, 1'b0, "R8 neighbour kept", 1'b1, 1'b0, {16'h0d0d, 12'h002});
    fill(vpn(14, 5), 16'h0e0e, 4'b1111, "R8 refill cleared dirty", 1'b1, vpn(10, 5), 1'b0);
  endtask

  task automatic t_fault_state;
    fill(vpn(20, 9), 16'h0020, 4'b0100, "R5 fill x", 1'b0, '0, 1'b0);
    fill(vpn(21, 9), 16'h0021, 4'b1111, "R5 fill y", 1'b0, '0, 1'b0);
    probe(va(20, 9, 0), 2'b01, 1'b0, "R5 faulting write", 1'b1, 1'b1, '0);
    fill(vpn(22, 9), 16'h0022, 4'b1111, "R5 fault left lru and dirty", 1'b1, vpn(20, 9), 1'b0);
  endtask

  task automatic t_clash;
    fill(vpn(30, 7), 16'h0abc, 4'b1111, "R10 fill w", 1'b0, '0, 1'b0);
    drive_fill(vpn(31, 7), 16'h0bcd, 4'b1111);
    lk_valid_i = 1'b1; lk_vaddr_i = va(30, 7, 0); lk_acc_i = 2'b00; lk_user_i = 1'b0;
    #Q;
    chk("R10 same set miss", 32'(lk_hit_o), 32'd0);
    @(negedge clk);
    drive_fill(vpn(1, 8), 16'h0111, 4'b1111);
    lk_vaddr_i = va(1, 3, 12'h004);
    #Q;
    chk("R10 other set hit", 32'(lk_hit_o), 32'd1);
    chk("R10 other set paddr", 32'(lk_paddr_o), 32'({16'h1234, 12'h004}));
    @(negedge clk);
    fill_valid_i = 1'b0; lk_valid_i = 1'b0;
    probe(va(30, 7, 0), 2'b00, 1'b0, "R10 entry kept", 1'b1, 1'b0, {16'h0abc, 12'h000});
  endtask

  task automatic t_flush;
    flush_i = 1'b1;
    drive_fill(vpn(40, 2), 16'h0040, 4'b1111);
    @(negedge clk);
    flush_i = 1'b0; fill_valid_i = 1'b0;
    #Q;
    chk("R9 no notice", 32'(evict_valid_o), 32'd0);
    @(negedge clk);
    probe(va(1, 3, 0), 2'b00, 1'b0, "R9 flushed", 1'b0, 1'b0, '0);
    probe(va(40, 2, 0), 2'b00, 1'b0, "R9 fill dropped", 1'b0, 1'b0, '0);
    probe(va(30, 7, 0), 2'b00, 1'b0, "R9 flushed set7", 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_perm();
    t_replace();
    t_refill();
    t_fault_state();
    t_clash();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule